// File: doc/BRIEF.md
# Halt Mode Wake-Up Controller

This block sits beside a CPU core and decides when the core may leave a low-power halt mode, and what it does once it wakes. The core enters a halt by pulsing a halt request with a 2-bit mode select. There are three modes: a light idle, a deeper idle and a full stop. The controller then closes the core clock gate. While the gate is closed it watches the interrupt request lines, each of which carries a 3-bit level, and a non-maskable request. A per-mode permission register sets which sources may end the deeper idle and the stop modes. The light idle mode accepts every source.

When a permitted request appears, the controller issues a one-cycle wake pulse and presents the winning level. It also raises a flag that tells the core what to do next. The flag is set when the core should take the interrupt, because the level is greater than or equal to the CPU mask. The flag is clear when the core should only continue at the instruction after the halt. Leaving the stop mode first runs an oscillator warm-up countdown with the clock gate open. The request must stay asserted through the whole countdown, or it is dropped.

The controller is a four-state machine:
- `ST_RUN`: the core is running.
- `ST_HALTED`: the clock gate is closed.
- `ST_WARMUP`: the stop-mode countdown is running.
- `ST_WAKE`: the one-cycle wake outcome.

Its transitions are:
- run→halted: a halt is accepted with nothing pending.
- run→wake: a halt is requested while a permitted request is already pending.
- halted→wake: an idle mode is released.
- halted→warmup: the stop mode is released.
- warmup→halted: the request is dropped.
- warmup→wake: the countdown expires.
- wake→run: always, after one cycle.

Top module: `halt_wake_ctrl`

## Requirements
- R1: Reset, which is asynchronous and active low, ends any halt mode and any warm-up without a wake pulse. While in reset and afterwards, clk_en=1, wake_pulse=0, take_irq=0 and wake_lvl=0. Both permission vectors reset to zero, and the warm-up reload resets to WARM_INIT.
- R2: The mode encodings are 00 = light idle, 01 = deep idle, 10 = stop and 11 = invalid. A halt_req with a valid mode, made while running with no permitted request pending, makes clk_en 0 from the next cycle on. A halt_req with mode 11 is ignored.
- R3: Suppose a halt_req arrives while a permitted request is already pending. Then clk_en never falls, and wake_pulse is asserted in the next cycle.
- R4: In the light idle mode, any asserted request line releases the halt. The wake_pulse follows in the cycle after the request is first seen.
- R5: In the deep idle mode only sources whose bit is set in the deep-idle permission vector release the halt. In the stop mode only sources whose bit is set in the stop permission vector release it. Other requests leave clk_en at 0 and produce no wake pulse.
- R6: wake_lvl is the highest level among the permitted pending requests. take_irq is 1 when that level is greater than or equal to cpu_mask, and 0 otherwise, in which case the core resumes after the halt.
- R7: The non-maskable request releases every mode, with wake_lvl=7 and take_irq=1 whatever the mask.
- R8: In the stop mode, clk_en rises in the cycle after a permitted request is first seen. The wake_pulse follows reload+1 cycles after clk_en rises.
- R9: If the permitted request disappears during warm-up, or on the same edge the countdown would expire, clk_en returns to 0 and no wake pulse is produced.
- R10: The permission vectors (perm_load) and the warm-up reload (warm_load) are loaded only while running. Loads attempted while halted have no effect.
- R11: wake_pulse lasts exactly one cycle, and the core is running again afterwards. take_irq and wake_lvl are 0 outside the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt request pulse from the core |
| halt_mode | input | 2 | Requested mode: 00 light idle, 01 deep idle, 10 stop |
| irq_req | input | N_SRC | Interrupt request lines |
| irq_lvl | input | N_SRC*3 | Level per source, source i in bits [3i+2:3i] |
| nmi_req | input | 1 | Non-maskable request (level 7) |
| cpu_mask | input | 3 | Current CPU interrupt mask |
| perm_load | input | 1 | Load both permission vectors (only while running) |
| perm_idle1 | input | N_SRC | Sources permitted to end deep idle |
| perm_stop | input | N_SRC | Sources permitted to end stop |
| warm_load | input | 1 | Load the warm-up reload (only while running) |
| warm_reload | input | WARM_W | Warm-up reload value |
| clk_en | output | 1 | Core clock-gate enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| take_irq | output | 1 | 1 take interrupt, 0 resume after the halt |
| wake_lvl | output | 3 | Winning request level |

## Verification
Two events can fall on the same clock edge: the warm-up countdown reaching its expiry edge, and the permitted request being withdrawn. The bench provokes this in stop mode by holding the request through exactly reload+1 edges and releasing it just before the edge that would fire the wake. The drop must win: the reference model expects clk_en back at 0 and no wake pulse. The bench also counts wake pulses so that a late spurious pulse would still be caught.

// File: rtl/hwk_pkg.sv
package hwk_pkg;
    localparam int LVL_W   = 3;
    localparam int NMI_LVL = 7;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_HALTED,
        ST_WARMUP,
        ST_WAKE
    } hwk_state_t;

    typedef enum logic [1:0] {
        HM_IDLE2 = 2'b00,
        HM_IDLE1 = 2'b01,
        HM_STOP  = 2'b10,
        HM_NONE  = 2'b11
    } hwk_mode_t;
endpackage

// File: rtl/hwk_perm.sv
module hwk_perm
    import hwk_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [N_SRC-1:0] idle1_in,
    input  logic [N_SRC-1:0] stop_in,
    input  hwk_mode_t        mode,
    input  logic [N_SRC-1:0] req,
    output logic [N_SRC-1:0] eligible
);
    logic [N_SRC-1:0] en_idle1_q;
    logic [N_SRC-1:0] en_stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_idle1_q <= '0;
            en_stop_q  <= '0;
        end else if (load_en) begin
            en_idle1_q <= idle1_in;
            en_stop_q  <= stop_in;
        end
    end

    always_comb begin
        unique case (mode)
            HM_IDLE2: eligible = req;
            HM_IDLE1: eligible = req & en_idle1_q;
            HM_STOP:  eligible = req & en_stop_q;
            default:  eligible = '0;
        endcase
    end
endmodule

// File: rtl/hwk_arb.sv
module hwk_arb
    import hwk_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] lvl_flat,
    input  logic                   nmi,
    output logic                   any,
    output logic [LVL_W-1:0]       win_lvl
);
    always_comb begin
        any     = 1'b0;
        win_lvl = '0;
        // descending scan with >= leaves the lowest index on a tie
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!any || lvl_flat[i*LVL_W +: LVL_W] >= win_lvl)) begin
                win_lvl = lvl_flat[i*LVL_W +: LVL_W];
                any     = 1'b1;
            end
        end
        if (nmi) begin
            win_lvl = LVL_W'(NMI_LVL);
            any     = 1'b1;
        end
    end
endmodule

// File: rtl/hwk_warm.sv
module hwk_warm #(
    parameter int          CNT_W = 16,
    parameter logic [15:0] INIT  = 16'd20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_val,
    input  logic             start,
    input  logic             count_en,
    output logic             expired
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= CNT_W'(INIT);
            cnt_q    <= '0;
        end else begin
            if (cfg_load) reload_q <= cfg_val;
            if (start)
                cnt_q <= reload_q;
            else if (count_en && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwk_pkg::*;
#(
    parameter int          N_SRC     = 8,
    parameter int          WARM_W    = 16,
    parameter logic [15:0] WARM_INIT = 16'd20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   halt_req,
    input  logic [1:0]             halt_mode,
    input  logic [N_SRC-1:0]       irq_req,
    input  logic [N_SRC*LVL_W-1:0] irq_lvl,
    input  logic                   nmi_req,
    input  logic [LVL_W-1:0]       cpu_mask,
    input  logic                   perm_load,
    input  logic [N_SRC-1:0]       perm_idle1,
    input  logic [N_SRC-1:0]       perm_stop,
    input  logic                   warm_load,
    input  logic [WARM_W-1:0]      warm_reload,
    output logic                   clk_en,
    output logic                   wake_pulse,
    output logic                   take_irq,
    output logic [LVL_W-1:0]       wake_lvl
);
    hwk_state_t       st_q, st_nxt;
    hwk_mode_t        mode_q, mode_sel;
    logic [N_SRC-1:0] eligible;
    logic             pend;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W-1:0] lvl_q;
    logic             take_q;
    logic             halt_ok;
    logic             latch_win;
    logic             warm_start;
    logic             warm_zero;
    logic             running;

    assign running  = (st_q == ST_RUN);
    assign halt_ok  = halt_req && (hwk_mode_t'(halt_mode) != HM_NONE);
    assign mode_sel = running ? hwk_mode_t'(halt_mode) : mode_q;

    hwk_perm #(.N_SRC(N_SRC)) u_perm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (perm_load && running),
        .idle1_in (perm_idle1),
        .stop_in  (perm_stop),
        .mode     (mode_sel),
        .req      (irq_req),
        .eligible (eligible)
    );

    hwk_arb #(.N_SRC(N_SRC)) u_arb (
        .req      (eligible),
        .lvl_flat (irq_lvl),
        .nmi      (nmi_req),
        .any      (pend),
        .win_lvl  (win_lvl)
    );

    hwk_warm #(.CNT_W(WARM_W), .INIT(WARM_INIT)) u_warm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (warm_load && running),
        .cfg_val  (warm_reload),
        .start    (warm_start),
        .count_en (st_q == ST_WARMUP),
        .expired  (warm_zero)
    );

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_RUN:    if (halt_ok) st_nxt = pend ? ST_WAKE : ST_HALTED;
            ST_HALTED: if (pend) st_nxt = (mode_q == HM_STOP) ? ST_WARMUP : ST_WAKE;
            ST_WARMUP: begin
                if (!pend)          st_nxt = ST_HALTED;
                else if (warm_zero) st_nxt = ST_WAKE;
            end
            ST_WAKE:   st_nxt = ST_RUN;
            default:   st_nxt = ST_RUN;
        endcase
    end

    assign latch_win  = (st_nxt == ST_WAKE) && (st_q != ST_WAKE);
    assign warm_start = (st_q == ST_HALTED) && (st_nxt == ST_WARMUP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            mode_q <= HM_IDLE2;
            lvl_q  <= '0;
            take_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (running && halt_ok) mode_q <= hwk_mode_t'(halt_mode);
            if (latch_win) begin
                lvl_q  <= win_lvl;
                take_q <= (win_lvl >= cpu_mask);
            end
        end
    end

    // outputs
    always_comb begin
        clk_en     = (st_q != ST_HALTED);
        wake_pulse = (st_q == ST_WAKE);
        take_irq   = wake_pulse ? take_q : 1'b0;
        wake_lvl   = wake_pulse ? lvl_q : '0;
    end

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    p_gate_needs_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> ($past(halt_req) || $past(st_q) == ST_WARMUP));

    p_stop_no_direct_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && !$past(clk_en)) |-> (mode_q != HM_STOP));

    p_warm_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARMUP && warm_zero) |=> (st_q != ST_WARMUP));

    p_drop_no_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARMUP && !pend) |=> !wake_pulse);

    p_nmi_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse && $past(nmi_req) && $past(st_q) != ST_WAKE) |-> (wake_lvl == 3'd7 && take_irq));
endmodule

// File: tb/halt_wake_ctrl_bench.sv
module halt_wake_ctrl_bench;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halt_req = 1'b0;
    logic [1:0]   halt_mode = 2'b00;
    logic [N-1:0] irq_req = '0;
    logic [N*3-1:0] irq_lvl = '0;
    logic         nmi_req = 1'b0;
    logic [2:0]   cpu_mask = 3'd0;
    logic         perm_load = 1'b0;
    logic [N-1:0] perm_idle1 = '0;
    logic [N-1:0] perm_stop = '0;
    logic         warm_load = 1'b0;
    logic [15:0]  warm_reload = '0;
    logic         clk_en, wake_pulse, take_irq;
    logic [2:0]   wake_lvl;

    int checks = 0;
    int errors = 0;
    int nwake  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    halt_wake_ctrl u_halt_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_mode(halt_mode),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .nmi_req(nmi_req), .cpu_mask(cpu_mask),
        .perm_load(perm_load), .perm_idle1(perm_idle1), .perm_stop(perm_stop),
        .warm_load(warm_load), .warm_reload(warm_reload),
        .clk_en(clk_en), .wake_pulse(wake_pulse), .take_irq(take_irq), .wake_lvl(wake_lvl)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: phase 0 run, 1 halted, 2 warm-up, 3 wake
    int m_ph = 0, m_mode = 0, m_cnt = 0, m_lvl = 0, m_take = 0, m_reload = 20;
    logic [N-1:0] m_p1 = '0, m_p2 = '0;

    function automatic int best_level(input int mode);
        int best = -1;
        for (int i = 0; i < N; i++) begin
            bit ok = irq_req[i] && (mode == 0 || (mode == 1 && m_p1[i]) || (mode == 2 && m_p2[i]));
            if (ok && int'(irq_lvl[i*3 +: 3]) > best) best = int'(irq_lvl[i*3 +: 3]);
        end
        if (nmi_req) best = 7;
        return best;
    endfunction

    task automatic grab(input int lv);
        m_lvl  = lv;
        m_take = (lv >= int'(cpu_mask)) ? 1 : 0;
        m_ph   = 3;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_p1 = '0; m_p2 = '0; m_reload = 20; m_lvl = 0; m_take = 0;
        end else begin
            case (m_ph)
                0: begin
                    int b;
                    b = best_level(int'(halt_mode));
                    if (halt_req && halt_mode != 2'b11) begin
                        if (b >= 0) grab(b);
                        else begin m_mode = int'(halt_mode); m_ph = 1; end
                    end
                    if (perm_load) begin m_p1 = perm_idle1; m_p2 = perm_stop; end
                    if (warm_load) m_reload = int'(warm_reload);
                end
                1: begin
                    int b;
                    b = best_level(m_mode);
                    if (b >= 0) begin
                        if (m_mode == 2) begin m_ph = 2; m_cnt = m_reload; end
                        else grab(b);
                    end
                end
                2: begin
                    int b;
                    b = best_level(2);
                    if (b < 0) m_ph = 1;
                    else if (m_cnt == 0) grab(b);
                    else m_cnt--;
                end
                default: m_ph = 0;
            endcase
        end
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            string tag;
            case (m_ph)
                0: tag = "R3";
                1: tag = "R5";
                2: tag = "R8";
                default: tag = "R6";
            endcase
            check({tag, " clk_en"}, int'(clk_en), (m_ph != 1) ? 1 : 0);
            check({tag, " wake_pulse"}, int'(wake_pulse), (m_ph == 3) ? 1 : 0);
            check({tag, " take_irq"}, int'(take_irq), (m_ph == 3) ? m_take : 0);
            check({tag, " wake_lvl"}, int'(wake_lvl), (m_ph == 3) ? m_lvl : 0);
            if (wake_pulse) nwake++;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_irq(input int idx, input bit on, input int lv);
        irq_req[idx] = on;
        irq_lvl[idx*3 +: 3] = 3'(lv);
    endtask

    task automatic do_halt(input logic [1:0] m);
        halt_req = 1'b1; halt_mode = m;
        tick();
        halt_req = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        tick();
        check("R1 reset clk_en", int'(clk_en), 1);
        check("R1 reset wake", int'(wake_pulse), 0);
        tick(); rst_n = 1'b1; tick();

        // configuration (R10): deep idle -> sources 0,2 ; stop -> source 1
        perm_load = 1'b1; perm_idle1 = 8'b0000_0101; perm_stop = 8'b0000_0010;
        warm_load = 1'b1; warm_reload = 16'd3;
        tick(); perm_load = 1'b0; warm_load = 1'b0;

        // mode 11 ignored (R2)
        do_halt(2'b11);
        check("R2 invalid mode ignored", int'(clk_en), 1);
        tick();

        // light idle, resume case (R2 R4 R6)
        cpu_mask = 3'd4;
        do_halt(2'b00);
        check("R2 gate closed", int'(clk_en), 0);
        set_irq(6, 1, 2);
        tick();
        check("R4 wake on any line", int'(wake_pulse), 1);
        check("R6 resume level", int'(wake_lvl), 2);
        check("R6 resume flag", int'(take_irq), 0);
        set_irq(6, 0, 0);
        tick();
        check("R11 pulse ends", int'(wake_pulse), 0);
        check("R11 level cleared", int'(wake_lvl), 0);

        // light idle, highest level wins, take (R6)
        cpu_mask = 3'd3;
        do_halt(2'b00);
        set_irq(0, 1, 1); set_irq(1, 1, 5); set_irq(3, 1, 5);
        tick();
        check("R6 highest level", int'(wake_lvl), 5);
        check("R6 take flag", int'(take_irq), 1);
        irq_req = '0;
        tick();

        // deep idle filters (R5)
        do_halt(2'b01);
        set_irq(1, 1, 6);
        repeat (4) tick();
        check("R5 unpermitted ignored", int'(clk_en), 0);
        set_irq(1, 0, 0); set_irq(2, 1, 6);
        tick();
        check("R5 permitted wakes", int'(wake_lvl), 6);
        irq_req = '0;
        tick();

        // stop with warm-up timing (R8)
        cpu_mask = 3'd0;
        do_halt(2'b10);
        set_irq(0, 1, 7);
        repeat (3) tick();
        check("R5 stop ignores source 0", int'(clk_en), 0);
        set_irq(0, 0, 0); set_irq(1, 1, 3);
        tick();
        check("R8 clk_en rises", int'(clk_en), 1);
        repeat (3) tick();
        check("R8 no early wake", int'(wake_pulse), 0);
        tick();
        check("R8 wake after reload+1", int'(wake_pulse), 1);
        check("R8 wake level", int'(wake_lvl), 3);
        irq_req = '0;
        tick();

        // drop during warm-up (R9), then NMI (R7)
        cpu_mask = 3'd7;
        do_halt(2'b10);
        set_irq(1, 1, 3);
        repeat (2) tick();
        set_irq(1, 0, 0);
        tick();
        check("R9 dropped request", int'(clk_en), 0);
        nmi_req = 1'b1;
        repeat (5) tick();
        check("R7 nmi wake", int'(wake_pulse), 1);
        check("R7 nmi level", int'(wake_lvl), 7);
        check("R7 nmi take", int'(take_irq), 1);
        nmi_req = 1'b0;
        tick();

        // drop on the expiry edge (R9)
        w0 = nwake;
        do_halt(2'b10);
        set_irq(1, 1, 3);
        repeat (4) tick();
        set_irq(1, 0, 0);
        tick();
        check("R9 expiry vs drop clk_en", int'(clk_en), 0);
        repeat (3) tick();
        check("R9 no wake pulse", nwake - w0, 0);
        nmi_req = 1'b1;
        repeat (6) tick();
        nmi_req = 1'b0;
        tick();

        // halt with request already pending (R3)
        set_irq(4, 1, 2);
        halt_req = 1'b1; halt_mode = 2'b00;
        tick(); halt_req = 1'b0;
        check("R3 gate stays open", int'(clk_en), 1);
        check("R3 immediate wake", int'(wake_pulse), 1);
        irq_req = '0;
        tick();

        // loads while halted ignored (R10)
        do_halt(2'b01);
        perm_load = 1'b1; perm_idle1 = '1;
        tick(); perm_load = 1'b0;
        set_irq(1, 1, 4);
        repeat (3) tick();
        check("R10 load ignored while halted", int'(clk_en), 0);

        // reset ends halt (R1)
        rst_n = 1'b0;
        #1;
        check("R1 reset ends halt", int'(clk_en), 1);
        check("R1 no pulse on reset", int'(wake_pulse), 0);
        tick(); rst_n = 1'b1; irq_req = '0;
        repeat (3) tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule